// File: doc/BRIEF.md
# Run-Length Framebuffer Row Compressor

This block holds a small framebuffer twice: once as plain pixels and once as a run-length-encoded image kept separately for each row. Every row has a validity flag. A display reader asks for one row at a time. The block streams that row back one pixel per cycle, in column order. It takes the pixels from the encoded copy when the row's flag is set and from the plain pixels when it is not. A pixel write from the renderer goes to the plain copy. The write clears the row's flag and marks the row as changed.

A background encoder keeps the compressed image up to date. When the number of changed rows reaches a threshold, it walks the rows from first to last. It re-encodes every row that is not valid and sets the row's flag when the encoding fits. Each run is stored as an 8-bit length and one pixel value, so a run longer than 255 pixels becomes two or more runs. A row that needs more runs than the per-row budget stays invalid and is always read from the plain copy. If the renderer writes to a row while the encoder is working on it, that row's result is thrown away.

The reader keeps working while the encoder runs. Rows that are not yet valid come from the plain copy.

Top module: `rlefb_top`

## Requirements
- R1: During reset, no pixel is output and both busy outputs are low. After reset every row counts as changed and invalid, so an encoding pass starts within a few cycles. Once that pass finishes, every row reads back all-zero pixels from the compressed path.
- R2: When `rd_start` is accepted while `rd_busy` is low, the block returns exactly WIDTH pixels on consecutive cycles, column 0 first. A `rd_start` that arrives while `rd_busy` is high is ignored.
- R3: Every pixel returned equals the last value written to that position, whichever path supplies it.
- R4: A write to a row makes that row invalid. A later read of that row reports `px_from_comp` = 0 until the row is re-encoded.
- R5: A read of a valid row reports `px_from_comp` = 1 on every pixel.
- R6: A run is stored as an 8-bit length from 1 to 255 and one pixel. A uniform row wider than 255 pixels is split into several runs and still reads back correctly from the compressed path.
- R7: A row needing at most MAX_RUNS runs becomes valid. A row needing more stays invalid and is read from the plain path.
- R8: A pass starts only when the count of changed rows reaches THRESH. While fewer rows have changed, no pass starts and the written rows read from the plain path.
- R9: After a pass, every row that was invalid, fits the budget and was not written during its own encoding is valid.
- R10: A write to a row while that row is being encoded cancels its result, so the row stays invalid after the pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Pixel write strobe |
| wr_row | input | ROW_W | Row of the pixel write |
| wr_col | input | COL_W | Column of the pixel write |
| wr_pix | input | PIX_W | Pixel value written |
| rd_start | input | 1 | Request a row read; taken only when `rd_busy` is low |
| rd_row | input | ROW_W | Row to read |
| rd_busy | output | 1 | A row read is in progress |
| px_valid | output | 1 | `px_data` carries a pixel this cycle |
| px_data | output | PIX_W | Pixel value, in column order |
| px_from_comp | output | 1 | 1 when the pixel comes from the compressed copy |
| recomp_busy | output | 1 | An encoding pass is running |

## Verification
The bench sets up two edge cases. One row needs exactly the run budget, and the next row needs one run more. A design with an off-by-one budget check would then either read the first row raw or hand out a truncated encoding for the second. A uniform 272-pixel row tests the 255-pixel run split: an encoder without it would wrap the run length and the read would return too few pixels. The bench writes changed rows one short of the threshold and checks that no pass starts, then adds the row that reaches it. It also writes into a row about five cycles after its encoding begins. A design that commits anyway would stream stale compressed pixels for that row. Finally, a read request made during a read would show up as extra or wrong pixels if the design accepted it.

// File: rtl/rlefb_pkg.sv
// Shared types for the run-length framebuffer compressor.
// Assumes run lengths are held in 8 bits throughout the block.
package rlefb_pkg;
    localparam int unsigned RUN_LEN_W = 8;
    localparam int unsigned RUN_MAX   = 255;

    typedef logic [RUN_LEN_W-1:0] run_len_t;

    typedef enum logic [1:0] {
        ENC_IDLE,
        ENC_PICK,
        ENC_SCAN,
        ENC_COMMIT
    } enc_state_e;
endpackage

// File: rtl/rlefb_rowstate.sv
// Per-row validity and change tracking, plus the pass trigger.
// Assumes a write always wins over an encoder commit or row-begin for the
// same row in the same cycle. All rows start changed and invalid.
module rlefb_rowstate #(
    parameter int ROWS   = 8,
    parameter int THRESH = 4,
    localparam int ROW_W = $clog2(ROWS),
    localparam int CNT_W = $clog2(ROWS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] wr_row,
    input  logic             begin_en,
    input  logic [ROW_W-1:0] begin_row,
    input  logic             commit_en,
    input  logic             commit_ok,
    input  logic [ROW_W-1:0] commit_row,
    input  logic             enc_busy,
    output logic [ROWS-1:0]  valid_q,
    output logic             trig
);
    logic [ROWS-1:0]  dirty_q;
    logic [CNT_W-1:0] dirty_cnt;

    // Validity: cleared by a write, set by a clean encoder commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            for (int i = 0; i < ROWS; i++) begin
                if (wr_en && wr_row == ROW_W'(i))
                    valid_q[i] <= 1'b0;
                else if (commit_en && commit_ok && commit_row == ROW_W'(i))
                    valid_q[i] <= 1'b1;
            end
        end
    end

    // Change flags: set by a write, cleared when the encoder takes the row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty_q <= '1;
        end else begin
            for (int i = 0; i < ROWS; i++) begin
                if (wr_en && wr_row == ROW_W'(i))
                    dirty_q[i] <= 1'b1;
                else if (begin_en && begin_row == ROW_W'(i))
                    dirty_q[i] <= 1'b0;
            end
        end
    end

    // Count the changed rows and compare the count with the threshold.
    always_comb begin
        dirty_cnt = '0;
        for (int i = 0; i < ROWS; i++)
            dirty_cnt = dirty_cnt + CNT_W'(dirty_q[i]);
        trig = (dirty_cnt >= CNT_W'(THRESH));
    end

    p_write_invalidates_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !valid_q[$past(wr_row)]);

    p_pass_needs_threshold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enc_busy) |-> $past(dirty_cnt >= CNT_W'(THRESH)));

    for (genvar g = 0; g < ROWS; g++) begin : g_rowchk
        p_valid_only_by_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(valid_q[g]) |-> $past(commit_en && commit_ok && commit_row == ROW_W'(g)));
    end
endmodule

// File: rtl/rlefb_encoder.sv
// Background encoder: walks the rows in ascending order and re-encodes each
// invalid row, reading one raw pixel per cycle. Runs go straight into the
// compressed store. This is safe because readers only use the compressed
// copy of a valid row. Assumes the raw read data is combinational from
// (rd_row, rd_col).
module rlefb_encoder
    import rlefb_pkg::*;
#(
    parameter int ROWS     = 8,
    parameter int WIDTH    = 272,
    parameter int PIX_W    = 8,
    parameter int MAX_RUNS = 6,
    localparam int ROW_W   = $clog2(ROWS),
    localparam int COL_W   = $clog2(WIDTH),
    localparam int RUN_W   = $clog2(MAX_RUNS),
    localparam int NR_W    = $clog2(MAX_RUNS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [ROWS-1:0]  row_valid,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [PIX_W-1:0] rd_pix,
    output logic [ROW_W-1:0] rd_row,
    output logic [COL_W-1:0] rd_col,
    output logic             busy,
    output logic             begin_en,
    output logic             run_we,
    output logic [RUN_W-1:0] run_idx,
    output run_len_t         run_len,
    output logic [PIX_W-1:0] run_pix,
    output logic             commit_en,
    output logic             commit_ok
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(WIDTH - 1);

    enc_state_e       st_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [PIX_W-1:0] cur_pix_q;
    run_len_t         cur_len_q;
    logic [NR_W-1:0]  nruns_q;
    logic             over_q;
    logic             abort_q;
    logic             wr_hit;
    logic             brk;
    logic             room;

    // Decode of the current cycle: run break, store slot available, write hit.
    always_comb begin
        wr_hit    = wr_en && (wr_row == row_q);
        room      = (nruns_q < NR_W'(MAX_RUNS));
        brk       = (st_q == ENC_SCAN) && (col_q != '0) &&
                    ((rd_pix != cur_pix_q) || (cur_len_q == run_len_t'(RUN_MAX)));
        begin_en  = (st_q == ENC_PICK) && !row_valid[row_q];
        run_we    = (brk || (st_q == ENC_COMMIT)) && room;
        run_idx   = RUN_W'(nruns_q);
        run_len   = cur_len_q;
        run_pix   = cur_pix_q;
        commit_en = (st_q == ENC_COMMIT);
        commit_ok = !abort_q && !wr_hit && !over_q && room;
        busy      = (st_q != ENC_IDLE);
        rd_row    = row_q;
        rd_col    = col_q;
    end

    // Pass sequencing and run building, one raw pixel per scan cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ENC_IDLE;
            row_q     <= '0;
            col_q     <= '0;
            cur_pix_q <= '0;
            cur_len_q <= '0;
            nruns_q   <= '0;
            over_q    <= 1'b0;
            abort_q   <= 1'b0;
        end else begin
            case (st_q)
                ENC_IDLE: begin
                    if (trig) begin
                        row_q <= '0;
                        st_q  <= ENC_PICK;
                    end
                end
                ENC_PICK: begin
                    if (row_valid[row_q]) begin
                        if (row_q == LAST_ROW) st_q <= ENC_IDLE;
                        else row_q <= row_q + 1'b1;
                    end else begin
                        col_q   <= '0;
                        nruns_q <= '0;
                        over_q  <= 1'b0;
                        abort_q <= wr_hit;
                        st_q    <= ENC_SCAN;
                    end
                end
                ENC_SCAN: begin
                    abort_q <= abort_q | wr_hit;
                    if (col_q == '0 || brk) begin
                        cur_pix_q <= rd_pix;
                        cur_len_q <= run_len_t'(1);
                    end else begin
                        cur_len_q <= cur_len_q + 1'b1;
                    end
                    if (brk) begin
                        if (room) nruns_q <= nruns_q + 1'b1;
                        else over_q <= 1'b1;
                    end
                    if (col_q == LAST_COL) st_q <= ENC_COMMIT;
                    else col_q <= col_q + 1'b1;
                end
                default: begin
                    if (row_q == LAST_ROW) begin
                        st_q <= ENC_IDLE;
                    end else begin
                        row_q <= row_q + 1'b1;
                        st_q  <= ENC_PICK;
                    end
                end
            endcase
        end
    end

    p_run_len_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run_we |-> (run_len != '0));

    p_run_slot_in_budget_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_we |-> (int'(run_idx) < MAX_RUNS));
endmodule

// File: rtl/rlefb_scanout.sv
// Row reader: streams WIDTH pixels of one row, one per cycle, choosing the
// compressed or raw copy once at the start from the row's validity flag.
// Assumes the renderer does not write a row while it is being read, and
// that the store read data is combinational from the index outputs.
module rlefb_scanout
    import rlefb_pkg::*;
#(
    parameter int ROWS     = 8,
    parameter int WIDTH    = 272,
    parameter int PIX_W    = 8,
    parameter int MAX_RUNS = 6,
    localparam int ROW_W   = $clog2(ROWS),
    localparam int COL_W   = $clog2(WIDTH),
    localparam int RUN_W   = $clog2(MAX_RUNS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_start,
    input  logic [ROW_W-1:0] rd_row,
    input  logic [ROWS-1:0]  row_valid,
    input  logic [PIX_W-1:0] raw_pix,
    input  run_len_t         run_len,
    input  logic [PIX_W-1:0] run_pix,
    output logic [ROW_W-1:0] sc_row,
    output logic [COL_W-1:0] sc_col,
    output logic [RUN_W-1:0] sc_idx,
    output logic             busy,
    output logic             px_valid,
    output logic [PIX_W-1:0] px_data,
    output logic             px_from_comp
);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(WIDTH - 1);

    logic             act_q;
    logic             comp_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] cnt_q;
    logic [RUN_W-1:0] ridx_q;
    run_len_t         rpos_q;
    logic             run_end;

    // Store addressing and end-of-run detection for the compressed walk.
    always_comb begin
        sc_row  = row_q;
        sc_col  = cnt_q;
        sc_idx  = ridx_q;
        busy    = act_q;
        run_end = ({1'b0, rpos_q} + 9'd1) == {1'b0, run_len};
    end

    // Request acceptance and per-cycle pixel emission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q        <= 1'b0;
            comp_q       <= 1'b0;
            row_q        <= '0;
            cnt_q        <= '0;
            ridx_q       <= '0;
            rpos_q       <= '0;
            px_valid     <= 1'b0;
            px_data      <= '0;
            px_from_comp <= 1'b0;
        end else begin
            px_valid <= 1'b0;
            if (!act_q) begin
                if (rd_start) begin
                    act_q  <= 1'b1;
                    row_q  <= rd_row;
                    comp_q <= row_valid[rd_row];
                    cnt_q  <= '0;
                    ridx_q <= '0;
                    rpos_q <= '0;
                end
            end else begin
                px_valid     <= 1'b1;
                px_data      <= comp_q ? run_pix : raw_pix;
                px_from_comp <= comp_q;
                if (comp_q) begin
                    if (run_end) begin
                        ridx_q <= ridx_q + 1'b1;
                        rpos_q <= '0;
                    end else begin
                        rpos_q <= rpos_q + 1'b1;
                    end
                end
                if (cnt_q == LAST_COL) act_q <= 1'b0;
                else cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    p_busy_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && act_q) |=> $stable(row_q));
endmodule

// File: rtl/rlefb_top.sv
// Run-length framebuffer compressor top: raw pixel store, per-row run
// store, row state, background encoder and row reader. Assumes at most one
// renderer write per cycle and no writes to a row while it is being read.
module rlefb_top
    import rlefb_pkg::*;
#(
    parameter int ROWS     = 8,
    parameter int WIDTH    = 272,
    parameter int PIX_W    = 8,
    parameter int MAX_RUNS = 6,
    parameter int THRESH   = 4,
    localparam int ROW_W   = $clog2(ROWS),
    localparam int COL_W   = $clog2(WIDTH),
    localparam int RUN_W   = $clog2(MAX_RUNS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [COL_W-1:0] wr_col,
    input  logic [PIX_W-1:0] wr_pix,
    input  logic             rd_start,
    input  logic [ROW_W-1:0] rd_row,
    output logic             rd_busy,
    output logic             px_valid,
    output logic [PIX_W-1:0] px_data,
    output logic             px_from_comp,
    output logic             recomp_busy
);
    logic [PIX_W-1:0] raw_mem [ROWS][WIDTH];
    run_len_t         len_mem [ROWS][MAX_RUNS];
    logic [PIX_W-1:0] val_mem [ROWS][MAX_RUNS];

    logic [ROWS-1:0]  row_valid;
    logic             trig;
    logic             enc_busy;
    logic             begin_en;
    logic             run_we;
    logic [RUN_W-1:0] run_idx;
    run_len_t         run_len;
    logic [PIX_W-1:0] run_pix;
    logic             commit_en;
    logic             commit_ok;
    logic [ROW_W-1:0] enc_row;
    logic [COL_W-1:0] enc_col;
    logic [PIX_W-1:0] enc_pix;
    logic [ROW_W-1:0] sc_row;
    logic [COL_W-1:0] sc_col;
    logic [RUN_W-1:0] sc_idx;
    logic [PIX_W-1:0] sc_raw;
    run_len_t         sc_len;
    logic [PIX_W-1:0] sc_val;

    // Raw pixel store: cleared by reset, written by the renderer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < WIDTH; c++)
                    raw_mem[r][c] <= '0;
        end else if (wr_en) begin
            raw_mem[wr_row][wr_col] <= wr_pix;
        end
    end

    // Run store: written only by the encoder, for the row it is encoding.
    always_ff @(posedge clk) begin
        if (run_we) begin
            len_mem[enc_row][run_idx] <= run_len;
            val_mem[enc_row][run_idx] <= run_pix;
        end
    end

    // Combinational read ports for the encoder and the reader.
    always_comb begin
        enc_pix     = raw_mem[enc_row][enc_col];
        sc_raw      = raw_mem[sc_row][sc_col];
        sc_len      = len_mem[sc_row][sc_idx];
        sc_val      = val_mem[sc_row][sc_idx];
        recomp_busy = enc_busy;
    end

    rlefb_rowstate #(.ROWS(ROWS), .THRESH(THRESH)) rowstate_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_row     (wr_row),
        .begin_en   (begin_en),
        .begin_row  (enc_row),
        .commit_en  (commit_en),
        .commit_ok  (commit_ok),
        .commit_row (enc_row),
        .enc_busy   (enc_busy),
        .valid_q    (row_valid),
        .trig       (trig)
    );

    rlefb_encoder #(.ROWS(ROWS), .WIDTH(WIDTH), .PIX_W(PIX_W), .MAX_RUNS(MAX_RUNS)) encoder_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .row_valid (row_valid),
        .wr_en     (wr_en),
        .wr_row    (wr_row),
        .rd_pix    (enc_pix),
        .rd_row    (enc_row),
        .rd_col    (enc_col),
        .busy      (enc_busy),
        .begin_en  (begin_en),
        .run_we    (run_we),
        .run_idx   (run_idx),
        .run_len   (run_len),
        .run_pix   (run_pix),
        .commit_en (commit_en),
        .commit_ok (commit_ok)
    );

    rlefb_scanout #(.ROWS(ROWS), .WIDTH(WIDTH), .PIX_W(PIX_W), .MAX_RUNS(MAX_RUNS)) scanout_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_start     (rd_start),
        .rd_row       (rd_row),
        .row_valid    (row_valid),
        .raw_pix      (sc_raw),
        .run_len      (sc_len),
        .run_pix      (sc_val),
        .sc_row       (sc_row),
        .sc_col       (sc_col),
        .sc_idx       (sc_idx),
        .busy         (rd_busy),
        .px_valid     (px_valid),
        .px_data      (px_data),
        .px_from_comp (px_from_comp)
    );
endmodule

// File: tb/rlefb_top_tb_top.sv
// Bench for rlefb_top: behavioural pixel model plus an expected-pixel queue,
// compared on every falling clock edge.
module rlefb_top_tb_top;
    localparam int ROWS  = 8;
    localparam int WIDTH = 272;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_row = '0;
    logic [8:0] wr_col = '0;
    logic [7:0] wr_pix = '0;
    logic       rd_start = 1'b0;
    logic [2:0] rd_row = '0;
    logic       rd_busy;
    logic       px_valid;
    logic [7:0] px_data;
    logic       px_from_comp;
    logic       recomp_busy;

    int   n_chk = 0;
    int   n_fail = 0;
    int   model [ROWS][WIDTH];
    int   exp_q [$];
    int   exp_comp = -1;
    string cur_req = "R3";
    bit   seen = 1'b0;

    always #5 clk = ~clk;

    rlefb_top dut_i (
        .clk (clk), .rst_n (rst_n),
        .wr_en (wr_en), .wr_row (wr_row), .wr_col (wr_col), .wr_pix (wr_pix),
        .rd_start (rd_start), .rd_row (rd_row), .rd_busy (rd_busy),
        .px_valid (px_valid), .px_data (px_data), .px_from_comp (px_from_comp),
        .recomp_busy (recomp_busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison of the pixel stream against the model queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (px_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 extra pixel", int'(px_data), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(int'(px_data) == e, {cur_req, " R3 pixel"}, int'(px_data), e);
                    if (exp_comp >= 0)
                        chk(int'(px_from_comp) == exp_comp, {cur_req, " path"},
                            int'(px_from_comp), exp_comp);
                    seen = 1'b1;
                end
            end else if (seen && exp_q.size() > 0) begin
                chk(1'b0, "R2 gap in stream", 0, 1);
            end
            if (exp_q.size() == 0) seen = 1'b0;
        end
    end

    task automatic wr(input int row, input int col, input int pix);
        @(negedge clk);
        wr_en = 1'b1; wr_row = 3'(row); wr_col = 9'(col); wr_pix = 8'(pix);
        model[row][col] = pix & 8'hFF;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Fill a row with nseg equal segments whose colours are base+segment.
    task automatic fill(input int row, input int nseg, input int base);
        for (int c = 0; c < WIDTH; c++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_row = 3'(row); wr_col = 9'(c);
            wr_pix = 8'(base + (c * nseg) / WIDTH);
            model[row][c] = (base + (c * nseg) / WIDTH) & 8'hFF;
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (recomp_busy || rd_busy || exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic scan(input int row, input int comp, input string req, input bit poke);
        wait_idle();
        rd_start = 1'b1; rd_row = 3'(row);
        exp_comp = comp; cur_req = req;
        for (int c = 0; c < WIDTH; c++) exp_q.push_back(model[row][c]);
        @(negedge clk);
        rd_start = 1'b0;
        if (poke) begin
            repeat (10) @(negedge clk);
            rd_start = 1'b1; rd_row = 3'((row + 1) % ROWS);
            @(negedge clk);
            rd_start = 1'b0;
        end
        while (exp_q.size() > 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(!px_valid && !rd_busy, "R2 stream ended", int'(px_valid), 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < WIDTH; c++) model[r][c] = 0;

        // R1: quiet during reset, pass starts right after.
        repeat (4) @(negedge clk);
        chk(!px_valid && !rd_busy && !recomp_busy, "R1 reset outputs", int'(px_valid), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(recomp_busy, "R1 initial pass", int'(recomp_busy), 1);
        scan(7, 1, "R1 R5", 1'b0);
        scan(2, 1, "R5", 1'b1);

        // R8: below threshold no pass; written rows read raw (R4).
        fill(1, 6, 8'h10);
        fill(3, 7, 8'h40);
        repeat (20) @(negedge clk);
        chk(!recomp_busy, "R8 below threshold", int'(recomp_busy), 0);
        scan(1, 0, "R4", 1'b0);
        fill(5, 1, 8'h5A);
        repeat (20) @(negedge clk);
        chk(!recomp_busy, "R8 three changed rows", int'(recomp_busy), 0);
        wr(0, 7, 8'h77);
        repeat (3) @(negedge clk);
        chk(recomp_busy, "R8 threshold reached", int'(recomp_busy), 1);
        wait_idle();
        scan(1, 1, "R7 R9 budget exact", 1'b0);
        scan(3, 0, "R7 over budget", 1'b0);
        scan(5, 1, "R6 long run split", 1'b0);
        scan(0, 1, "R9", 1'b0);
        scan(6, 1, "R5", 1'b0);

        // R10: write into row 0 while the pass encodes it.
        wr(2, 3, 8'h21);
        wr(4, 200, 8'h22);
        wr(6, 0, 8'h23);
        scan(6, 0, "R4", 1'b0);
        wr(0, 0, 8'h24);
        while (!recomp_busy) @(negedge clk);
        repeat (5) @(negedge clk);
        wr(0, 100, 8'h33);
        wait_idle();
        scan(0, 0, "R10 aborted row", 1'b0);
        scan(2, 1, "R9", 1'b0);
        scan(4, 1, "R9", 1'b1);
        scan(6, 1, "R9", 1'b0);
        scan(3, 0, "R7", 1'b0);
        repeat (50) @(negedge clk);
        chk(!recomp_busy, "R8 one changed row", int'(recomp_busy), 0);

        summary();
        $finish;
    end
endmodule